// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block is the host-side controller for a sampling analog-to-digital converter with a serial result output. A one-cycle start request makes the block drive the active-low chip-select and the active-low read/convert strobe in a fixed sequence. It then watches the converter's busy line. While the conversion runs, the converter shifts a 16-bit word out MSB first against a data clock that it generates itself, and the block captures that word. The converter returns the word of the *previous* conversion during the current one. The first word after power-up is therefore meaningless, and the block marks it as invalid.

The data clock, the data line and busy are asynchronous to the system clock, so each passes through a two-flop synchroniser. Bits are taken on the synchronised rising edge of the data clock. When busy has returned high and the full word has arrived, a one-cycle valid pulse publishes the result. A conversion that never starts, never ends or ends with too few bits is dropped and reported as an error. Through a parameter, chip-select can be held low for good, so that the read/convert strobe alone starts each conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, csN and rcN are high and resultValid, firstInvalid and seqError are low. When CS_TIED=1, csN is low instead of high.
- R2: With CS_TIED=0, a start request taken in idle pulls csN low. rcN then falls exactly LEAD_CYCLES clocks later. rcN is never low while csN is high.
- R3: Each conversion drives rcN low for exactly HOLD_CYCLES clocks, and does so only once.
- R4: With CS_TIED=1, csN stays low at all times, and rcN alone starts each conversion with the same width as in R3.
- R5: The result is formed from the data line, sampled on the first WORD_BITS rising edges of the synchronised data clock after the start. The first sampled bit becomes the MSB (bit WORD_BITS-1).
- R6: resultValid is a one-cycle pulse. It is raised only after busy has returned high with all WORD_BITS bits captured. result changes only in the cycle that resultValid is high, and it holds its value otherwise.
- R7: firstInvalid is high together with the first resultValid pulse after reset and low on every later one.
- R8: Start requests that arrive while a conversion is in progress are ignored: they cause no extra rcN pulse and no conversion afterwards.
- R9: If busy does not fall within TIMEOUT_CYCLES clocks after rcN is released, the block raises seqError for one cycle and returns to idle. In idle, csN and rcN are high, and no resultValid pulse is given.
- R10: If busy stays low for TIMEOUT_CYCLES clocks during a conversion, the block raises seqError for one cycle and returns to idle, with no resultValid pulse.
- R11: If busy returns high with fewer than WORD_BITS bits captured, the block raises seqError for one cycle and gives no resultValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to start a conversion |
| busyIn | input | 1 | Converter busy line, low while converting (asynchronous) |
| dataClkIn | input | 1 | Data clock generated by the converter (asynchronous) |
| dataIn | input | 1 | Serial result bit from the converter (asynchronous) |
| csN | output | 1 | Active-low chip-select |
| rcN | output | 1 | Active-low read/convert strobe |
| result | output | WORD_BITS | Last captured word |
| resultValid | output | 1 | One-cycle pulse when result is updated |
| firstInvalid | output | 1 | High with the first resultValid after reset: that word is indeterminate |
| seqError | output | 1 | One-cycle pulse when a conversion is aborted |

## Verification
The bench builds two copies side by side. The first uses CS_TIED=0, LEAD_CYCLES=2 and HOLD_CYCLES=10, which give a 10 ns lead and a 50 ns strobe at the 200 MHz clock. The second uses CS_TIED=1, so both strobe styles run under the same converter model. TIMEOUT_CYCLES is reduced to 300, which makes both abort paths, a missing busy fall and a stuck busy, reachable in a few hundred cycles. A truncated word of ten pulses is also sent to exercise the short-word abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef struct packed {
    logic clearCount;
    logic captureEn;
    logic publish;
  } dp_ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CS_LEAD,
    S_RC_HOLD,
    S_WAIT_FALL,
    S_CONVERT
  } seq_state_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= RESET_VAL;
    else       pipe[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[i] <= RESET_VAL;
      else       pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_ctrl_t             ctrl,
  input  logic                 busyIn,
  input  logic                 dataClkIn,
  input  logic                 dataIn,
  output logic                 busySync,
  output logic                 fullWord,
  output logic [WORD_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 firstInvalid
);

  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic [2:0] syncOut;
  logic dclkSync, dataSync, dclkPrev, dclkRise, seenResult;
  logic [CNT_W-1:0] bitCount;
  logic [WORD_BITS-1:0] shiftReg;

  adc_seq_sync #(
    .STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .din({busyIn, dataClkIn, dataIn}),
    .dout(syncOut)
  );

  assign busySync = syncOut[2];
  assign dclkSync = syncOut[1];
  assign dataSync = syncOut[0];
  assign dclkRise = dclkSync & ~dclkPrev;
  assign fullWord = (bitCount == CNT_W'(WORD_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dclkPrev <= 1'b0;
      bitCount <= '0;
      shiftReg <= '0;
    end else begin
      dclkPrev <= dclkSync;
      if (ctrl.clearCount) begin
        bitCount <= '0;
      end else if (ctrl.captureEn && dclkRise && !fullWord) begin
        bitCount <= bitCount + 1'b1;
        shiftReg <= {shiftReg[WORD_BITS-2:0], dataSync};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      resultValid  <= 1'b0;
      firstInvalid <= 1'b0;
      seenResult   <= 1'b0;
    end else begin
      resultValid  <= ctrl.publish;
      firstInvalid <= ctrl.publish & ~seenResult;
      if (ctrl.publish) begin
        result     <= shiftReg;
        seenResult <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
#(
  parameter int LEAD_CYCLES = 2,
  parameter int HOLD_CYCLES = 10,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter bit CS_TIED = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     busySync,
  input  logic     fullWord,
  output dp_ctrl_t ctrl,
  output logic     csN,
  output logic     rcN,
  output logic     seqError
);

  localparam int MAX_A = (LEAD_CYCLES > HOLD_CYCLES) ? LEAD_CYCLES : HOLD_CYCLES;
  localparam int TMAX  = (MAX_A > TIMEOUT_CYCLES) ? MAX_A : TIMEOUT_CYCLES;
  localparam int TW    = $clog2(TMAX + 1);

  seq_state_t state, nextState;
  logic [TW-1:0] timer;
  logic timerClr, errNext;

  always_comb begin
    nextState = state;
    timerClr  = 1'b0;
    errNext   = 1'b0;
    ctrl      = '0;
    ctrl.captureEn = (state != S_IDLE);
    case (state)
      S_IDLE: if (startReq) begin
        ctrl.clearCount = 1'b1;
        timerClr  = 1'b1;
        nextState = CS_TIED ? S_RC_HOLD : S_CS_LEAD;
      end
      S_CS_LEAD: if (timer == TW'(LEAD_CYCLES - 1)) begin
        nextState = S_RC_HOLD;
        timerClr  = 1'b1;
      end
      S_RC_HOLD: if (timer == TW'(HOLD_CYCLES - 1)) begin
        nextState = S_WAIT_FALL;
        timerClr  = 1'b1;
      end
      S_WAIT_FALL: begin
        if (!busySync) begin
          nextState = S_CONVERT;
          timerClr  = 1'b1;
        end else if (timer == TW'(TIMEOUT_CYCLES - 1)) begin
          errNext   = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_CONVERT: begin
        if (busySync) begin
          nextState = S_IDLE;
          if (fullWord) ctrl.publish = 1'b1;
          else          errNext = 1'b1;
        end else if (timer == TW'(TIMEOUT_CYCLES - 1)) begin
          errNext   = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      seqError <= 1'b0;
    end else begin
      state    <= nextState;
      seqError <= errNext;
      if (timerClr || state == S_IDLE) timer <= '0;
      else                             timer <= timer + 1'b1;
    end
  end

  assign csN = CS_TIED ? 1'b0 : (state == S_IDLE);
  assign rcN = (state != S_RC_HOLD);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_CYCLES = 2,
  parameter int HOLD_CYCLES = 10,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter bit CS_TIED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 busyIn,
  input  logic                 dataClkIn,
  input  logic                 dataIn,
  output logic                 csN,
  output logic                 rcN,
  output logic [WORD_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 firstInvalid,
  output logic                 seqError
);

  dp_ctrl_t ctrl;
  logic busySync, fullWord;

  adc_seq_control #(
    .LEAD_CYCLES(LEAD_CYCLES), .HOLD_CYCLES(HOLD_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CS_TIED(CS_TIED)
  ) u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .busySync(busySync), .fullWord(fullWord), .ctrl(ctrl),
    .csN(csN), .rcN(rcN), .seqError(seqError)
  );

  adc_seq_datapath #(
    .WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .busyIn(busyIn), .dataClkIn(dataClkIn), .dataIn(dataIn),
    .busySync(busySync), .fullWord(fullWord), .result(result),
    .resultValid(resultValid), .firstInvalid(firstInvalid)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int WORD_BITS = 16,
  parameter int HOLD_CYCLES = 10,
  parameter bit CS_TIED = 1'b0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 rcN,
  input logic [WORD_BITS-1:0] result,
  input logic                 resultValid,
  input logic                 firstInvalid,
  input logic                 seqError
);

  logic [31:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowRun <= '0;
    else if (rcN)             lowRun <= '0;
    else if (lowRun != '1)    lowRun <= lowRun + 1'b1;
  end

  // R2
  p_rc_inside_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rcN |-> !csN);
  // R3
  p_hold_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcN) |-> lowRun == 32'(HOLD_CYCLES));
  // R4
  p_cs_tied_r4: assert property (@(posedge clk) disable iff (!rstN)
    CS_TIED |-> !csN);
  // R6
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_result_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> resultValid);
  // R7
  p_first_with_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    firstInvalid |-> resultValid);
  // R9
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (rcN && !resultValid && (csN || CS_TIED)));
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> !seqError);

endmodule

bind adc_seq_ctrl adc_seq_checker #(
  .WORD_BITS(WORD_BITS), .HOLD_CYCLES(HOLD_CYCLES), .CS_TIED(CS_TIED)
) u_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .result(result),
  .resultValid(resultValid), .firstInvalid(firstInvalid), .seqError(seqError)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  localparam int WB = 16;
  localparam int LEAD = 2;
  localparam int HOLD = 10;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startA = 1'b0, startT = 1'b0;
  logic busy = 1'b1, dclk = 1'b0, data = 1'b0;
  logic csA, rcA, validA, firstA, errA;
  logic csT, rcT, validT, firstT, errT;
  logic [WB-1:0] resA, resT;

  int nChecks = 0, nErrors = 0, cyc = 0;
  bit finished = 0;
  bit activeA = 0, activeT = 0;
  bit selTied = 0;
  int rcFallsA = 0, rcFallsT = 0, lastGap = 0, lastWidthA = 0, lastWidthT = 0;
  int csFallCyc = 0, rcFallCycA = 0, rcFallCycT = 0;
  logic csPrev = 1'b1, rcPrevA = 1'b1, rcPrevT = 1'b1;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.WORD_BITS(WB), .LEAD_CYCLES(LEAD), .HOLD_CYCLES(HOLD),
                 .TIMEOUT_CYCLES(TMO), .CS_TIED(1'b0)) i_adc_seq_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startA), .busyIn(busy),
    .dataClkIn(dclk), .dataIn(data), .csN(csA), .rcN(rcA), .result(resA),
    .resultValid(validA), .firstInvalid(firstA), .seqError(errA));

  adc_seq_ctrl #(.WORD_BITS(WB), .LEAD_CYCLES(LEAD), .HOLD_CYCLES(HOLD),
                 .TIMEOUT_CYCLES(TMO), .CS_TIED(1'b1)) i_adc_seq_ctrl_tied (
    .clk(clk), .rstN(rstN), .startReq(startT), .busyIn(busy),
    .dataClkIn(dclk), .dataIn(data), .csN(csT), .rcN(rcT), .result(resT),
    .resultValid(validT), .firstInvalid(firstT), .seqError(errT));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  // strobe timing monitor and per-clock comparison against idle expectation
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (csPrev && !csA) csFallCyc = cyc;
      if (rcPrevA && !rcA) begin rcFallsA++; rcFallCycA = cyc; lastGap = cyc - csFallCyc; end
      if (!rcPrevA && rcA) lastWidthA = cyc - rcFallCycA;
      if (rcPrevT && !rcT) begin rcFallsT++; rcFallCycT = cyc; end
      if (!rcPrevT && rcT) lastWidthT = cyc - rcFallCycT;
      if (!rcA && csA) check(0, "R2", "rcN low with csN high", 1, 0);
      if (csT !== 1'b0) check(0, "R4", "tied csN", csT, 0);
      if (!activeA) begin
        if (csA !== 1'b1 || rcA !== 1'b1 || validA !== 1'b0)
          check(0, "R8", "idle strobes/valid A", {csA, rcA, validA}, 3'b110);
      end
      if (!activeT) begin
        if (rcT !== 1'b1 || validT !== 1'b0)
          check(0, "R8", "idle strobes/valid T", {rcT, validT}, 2'b10);
      end
    end
    csPrev = csA; rcPrevA = rcA; rcPrevT = rcT;
  end

  // converter model: waits for the strobe, then answers
  task automatic converter(input logic [WB-1:0] word, input int nPulses,
                           input bit doFall, input bit doRise, input bit extraStart);
    int guard = 0;
    while ((selTied ? rcT : rcA) !== 1'b0 && guard < 50) begin
      @(negedge clk); guard++;
    end
    if (!doFall) return;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    for (int i = 0; i < nPulses; i++) begin
      data = word[WB-1-i];
      repeat (2) @(negedge clk);
      dclk = 1'b1;
      if (extraStart && i == 4) begin
        if (selTied) startT = 1'b1; else startA = 1'b1;
      end
      repeat (3) @(negedge clk);
      startA = 1'b0; startT = 1'b0;
      dclk = 1'b0;
    end
    if (!doRise) return;
    repeat (3) @(negedge clk);
    busy = 1'b1;
  endtask

  // outcome: 0 = valid expected, 1 = error expected
  task automatic runConv(input bit tied, input logic [WB-1:0] word, input int nPulses,
                         input bit doFall, input bit doRise, input bit extraStart,
                         input bit expErr, input bit expFirst, input string req);
    int falls0, wait_n;
    bit gotV = 0, gotE = 0, gotF = 0;
    logic [WB-1:0] got = '0;
    selTied = tied;
    falls0 = tied ? rcFallsT : rcFallsA;
    @(negedge clk);
    if (tied) begin activeT = 1; startT = 1'b1; end
    else      begin activeA = 1; startA = 1'b1; end
    @(negedge clk);
    startA = 1'b0; startT = 1'b0;
    converter(word, nPulses, doFall, doRise, extraStart);
    wait_n = 0;
    while (!gotV && !gotE && wait_n < TMO + 100) begin
      if (tied ? validT : validA) begin gotV = 1; got = tied ? resT : resA; gotF = tied ? firstT : firstA; end
      if (tied ? errT : errA) gotE = 1;
      if (!gotV && !gotE) begin @(negedge clk); wait_n++; end
    end
    check(gotE == expErr, req, "error pulse", gotE, expErr);
    check(gotV == !expErr, req, "valid pulse", gotV, !expErr);
    if (!expErr) begin
      check(got == word, "R5", "captured word", got, word);
      check(gotF == expFirst, "R7", "first-invalid flag", gotF, expFirst);
    end
    @(negedge clk);
    if (tied) begin
      check((tied ? validT : validA) == 1'b0, "R6", "valid single cycle", validT, 0);
    end else begin
      check(validA == 1'b0, "R6", "valid single cycle", validA, 0);
      check(resA == (expErr ? resA : word), "R6", "result held", resA, word);
    end
    busy = 1'b1; dclk = 1'b0;
    repeat (8) @(negedge clk);
    if (tied) activeT = 0; else activeA = 0;
    check(((tied ? rcFallsT : rcFallsA) - falls0) == 1, "R8", "rcN pulses per conversion",
          (tied ? rcFallsT : rcFallsA) - falls0, 1);
    if (!tied) begin
      check(lastGap == LEAD, "R2", "csN to rcN lead", lastGap, LEAD);
      check(lastWidthA == HOLD, "R3", "rcN low width", lastWidthA, HOLD);
    end else begin
      check(lastWidthT == HOLD, "R4", "tied rcN low width", lastWidthT, HOLD);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(csA === 1'b1 && rcA === 1'b1, "R1", "reset strobes", {csA, rcA}, 2'b11);
    check(validA === 1'b0 && errA === 1'b0 && firstA === 1'b0, "R1", "reset flags",
          {validA, errA, firstA}, 0);
    check(csT === 1'b0 && rcT === 1'b1, "R1", "reset tied strobes", {csT, rcT}, 2'b01);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    runConv(0, 16'hA5C3, WB, 1, 1, 0, 0, 1, "R6");
    runConv(0, 16'h8001, WB, 1, 1, 0, 0, 0, "R6");
    runConv(0, 16'hFFFF, WB, 1, 1, 1, 0, 0, "R8");
    runConv(0, 16'h0000, WB, 1, 1, 0, 0, 0, "R5");
    runConv(1, 16'h3C5A, WB, 1, 1, 0, 0, 1, "R4");
    runConv(1, 16'h1234, WB, 1, 1, 0, 0, 0, "R4");
    runConv(0, 16'h0F0F, 0, 0, 1, 0, 1, 0, "R9");
    runConv(0, 16'h0F0F, WB, 1, 0, 0, 1, 0, "R10");
    runConv(0, 16'hC0DE, 10, 1, 1, 0, 1, 0, "R11");
    runConv(0, 16'h7E81, WB, 1, 1, 0, 0, 0, "R6");
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", 200000, 200000);
    finish();
  end

endmodule